// File: doc/BRIEF.md
# Serial-Bus Channel Selector Slave

This block is a two-wire serial bus slave that holds a single byte-wide selection register and drives eight channel-enable outputs from it. Each enable would steer an external bus switch that joins the upstream bus to one downstream segment. Any mix of segments may be joined at once, and so may none. The slave samples the bus clock and data lines with a fast system clock and ignores short spikes. It recognises start, repeated start and stop conditions. It answers at one of eight addresses chosen by three strap pins, and it takes writes to the register or sends the register back on reads.

A newly written selection sits in the register but does not reach the enable outputs until the master ends the transfer with a stop. Segments therefore join only while the bus is idle and high. The data line is modelled as an open-drain output enable: a high on `sda_oe_o` pulls the line low. The bus serial protocol is the data interface, so the block has no valid/ready handshake. Its strap, reset and enable pins are plain levels with no back-pressure.

Top module: `chsel_i2c_top`

## Requirements
- R1: The slave answers at the 7-bit address whose upper four bits are 1110 and whose lower three bits are `strap_i[2:0]` (0x70 to 0x77). The eighth address bit selects a read when it is 1 and a write when it is 0. On a match the slave pulls SDA low through the ninth clock.
- R2: On an address mismatch the slave never pulls SDA low and ignores the bus until the next start or stop. The register and the enable outputs are left unchanged.
- R3: In a write, each byte after the address is stored in the register and acknowledged. Register bit n selects channel n, and every value, 0x00 included, is legal.
- R4: When several data bytes follow the address in one write, only the last byte remains in the register.
- R5: `chan_en_o` takes the register value only when a stop condition is detected. Before that, the previous selection stays on the outputs.
- R6: A read sends the register MSB first. When the master acknowledges a byte, the same value is sent again. After the master does not acknowledge, the slave releases SDA.
- R7: Driving `rst_n` low clears the register and `chan_en_o` to 0x00 and returns the bus logic to idle.
- R8: A pulse on SCL or SDA that lasts fewer than SPIKE_CYC system clocks is rejected. A level is accepted only after it has held for SPIKE_CYC clocks.
- R9: A repeated start at any point returns the slave to the address phase.
- R10: The slave changes its SDA drive only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Low three address bits |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| chan_en_o | output | 8 | Channel enables, bit n for channel n |

## Verification
Every bus edge reaches the state machine two synchroniser clocks plus SPIKE_CYC filter clocks after the pin changes, so `sda_oe_o` moves about ten clocks after the SCL fall that triggers it. The bench model holds each quarter bit for 16 clocks. It reads acknowledge and read data in the middle of the SCL high phase, when every drive change has settled. It checks `chan_en_o` just before each stop, where the old value is expected, and a full quarter bit after the stop, where the new value is expected. The spike tests hold glitches for 3 clocks, which is below the filter length.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [3:0] ADDR_HI = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_IGNORE
  } chsel_state_e;
endpackage

// File: rtl/chsel_deglitch.sv
module chsel_deglitch #(
  parameter int unsigned SPIKE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic sync_o,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(SPIKE_CYC + 1);

  logic          meta_q, sync_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      if (sync_q != filt_q) begin
        if (cnt_q == CW'(SPIKE_CYC - 1)) begin
          filt_q <= sync_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign sync_o = sync_q;
  assign filt_o = filt_q;
endmodule

// File: rtl/chsel_bus_events.sv
module chsel_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign start_evt = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_evt  = scl_f & scl_d & ~sda_d & sda_f;
  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
endmodule

// File: rtl/chsel_slave_fsm.sv
module chsel_slave_fsm
  import chsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_f,
  input  logic [2:0]        strap,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] chan_en,
  output chsel_state_e      state
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  chsel_state_e      st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, ctrl_q, en_q;
  logic              oe_q, mack_q;
  logic              byte_done;

  assign byte_done = (cnt_q == CNT_W'(BYTE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      ctrl_q <= '0;
      en_q   <= '0;
      oe_q   <= 1'b0;
      mack_q <= 1'b0;
    end else if (stop_evt) begin
      st_q  <= ST_IDLE;
      oe_q  <= 1'b0;
      cnt_q <= '0;
      en_q  <= ctrl_q;
    end else if (start_evt) begin
      st_q  <= ST_ADDR;
      oe_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_f};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && byte_done) begin
            if (st_q == ST_WR) begin
              ctrl_q <= sh_q;
              st_q   <= ST_WR_ACK;
              oe_q   <= 1'b1;
            end else if (sh_q[BYTE_W-1:1] == {ADDR_HI, strap}) begin
              st_q <= ST_ADDR_ACK;
              oe_q <= 1'b1;
            end else begin
              st_q <= ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (sh_q[0]) begin
              st_q <= ST_RD;
              sh_q <= ctrl_q;
              oe_q <= ~ctrl_q[BYTE_W-1];
            end else begin
              st_q <= ST_WR;
              oe_q <= 1'b0;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            st_q  <= ST_WR;
            cnt_q <= '0;
            oe_q  <= 1'b0;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (byte_done) begin
              st_q <= ST_RD_ACK;
              oe_q <= 1'b0;
            end else begin
              sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
              oe_q <= ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_f;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_q  <= ST_RD;
              cnt_q <= '0;
              sh_q  <= ctrl_q;
              oe_q  <= ~ctrl_q[BYTE_W-1];
            end else begin
              st_q <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe  = oe_q;
  assign chan_en = en_q;
  assign state   = st_q;
endmodule

// File: rtl/chsel_i2c_top.sv
module chsel_i2c_top
  import chsel_pkg::*;
#(
  parameter int unsigned SPIKE_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] chan_en_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw, sync, filt;
  logic              scl_f, sda_f, scl_s;
  logic              start_evt, stop_evt, scl_rise, scl_fall;
  chsel_state_e      state;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    chsel_deglitch #(.SPIKE_CYC(SPIKE_CYC)) u_dg (
      .clk(clk), .rst_n(rst_n), .line_i(raw[g]),
      .sync_o(sync[g]), .filt_o(filt[g])
    );
  end

  assign scl_f = filt[0];
  assign sda_f = filt[1];
  assign scl_s = sync[0];

  chsel_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  chsel_slave_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_f(sda_f),
    .strap(strap_i), .sda_oe(sda_oe_o), .chan_en(chan_en_o), .state(state)
  );
endmodule

// File: rtl/chsel_i2c_chk.sv
module chsel_i2c_chk
  import chsel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              scl_s,
  input logic              stop_evt,
  input logic              sda_oe_o,
  input logic [BYTE_W-1:0] chan_en_o,
  input chsel_state_e      state
);
  // R5: the enables move only on the cycle after a stop
  assert_en_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en_o) |-> $past(stop_evt));

  // R10: the drive is turned on only while SCL is low
  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_f);

  // R7: on leaving reset, no channel is selected
  assert_reset_clear_R7: assert property (@(posedge clk)
    $rose(rst_n) |-> chan_en_o == '0);

  // R2: an ignoring slave never drives the bus
  assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IGNORE |-> !sda_oe_o);

  // R8: the filtered clock only takes a level the synchroniser presented
  assert_filter_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_f) |-> $past(scl_s) == scl_f);
endmodule

bind chsel_i2c_top chsel_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .scl_s(scl_s),
  .stop_evt(stop_evt), .sda_oe_o(sda_oe_o), .chan_en_o(chan_en_o), .state(state)
);

// File: tb/chsel_i2c_top_test.sv
module chsel_i2c_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int QB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sda_oe;
  logic [7:0] chan_en;
  logic       sda_line;

  int n_vec = 0, n_bad = 0;
  logic [7:0] exp_reg = 8'h00, exp_en = 8'h00;
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  int   viol = 0, oe_seen = 0;
  bit   mon = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  chsel_i2c_top uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .chan_en_o(chan_en)
  );

  // R10 and R2 bus monitor
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_oe != prev_oe)) viol++;
    if (mon && sda_oe) oe_seen++;
    prev_scl <= scl_m;
    prev_oe  <= sda_oe;
  end

  function automatic logic [6:0] dev_addr(input logic [2:0] s);
    return {4'b1110, s};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qb(); repeat (QB) @(negedge clk); endtask

  task automatic do_start();
    sda_m = 1'b1; scl_m = 1'b1; qb(); sda_m = 1'b0; qb(); scl_m = 1'b0; qb();
  endtask

  task automatic do_rstart();
    sda_m = 1'b1; qb(); scl_m = 1'b1; qb(); sda_m = 1'b0; qb(); scl_m = 1'b0; qb();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; qb(); scl_m = 1'b1; qb(); sda_m = 1'b1; qb();
  endtask

  // one bit; spk=1 adds a short SCL glitch in the low phase, spk=2 a short SDA dip while SCL is high
  task automatic do_bit(input logic b, input int spk, output logic got);
    sda_m = b; qb();
    scl_m = 1'b1;
    if (spk == 2) begin
      repeat (4) @(negedge clk); sda_m = 1'b0; repeat (3) @(negedge clk); sda_m = b;
      repeat (QB - 7) @(negedge clk);
    end else qb();
    got = sda_line; qb();
    scl_m = 1'b0;
    if (spk == 1) begin
      repeat (4) @(negedge clk); scl_m = 1'b1; repeat (3) @(negedge clk); scl_m = 1'b0;
      repeat (QB - 7) @(negedge clk);
    end else qb();
  endtask

  task automatic send_byte(input logic [7:0] v, input int spk, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) do_bit(v[i], (i == 4) ? spk : 0, g);
    do_bit(1'b1, 0, g);
    ack = ~g;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic g;
    for (int i = 7; i >= 0; i--) begin do_bit(1'b1, 0, g); v[i] = g; end
    do_bit(~mack, 0, g);
    sda_m = 1'b1;
  endtask

  task automatic write_txn(input logic match, input int nb, input int spk);
    logic ack; logic [7:0] d; logic [6:0] a;
    a = match ? dev_addr(strap) : {4'b1100, strap};
    do_start();
    send_byte({a, 1'b0}, 0, ack);
    chk(match ? "R1 address ack" : "R2 mismatch nack", ack, match);
    for (int k = 0; k < nb; k++) begin
      d = 8'($urandom);
      send_byte(d, spk, ack);
      if (match) begin chk("R3 data ack", ack, 1); exp_reg = d; end
    end
    chk("R5 held before stop", chan_en, exp_en);
    do_stop(); qb();
    exp_en = exp_reg;
    chk(nb > 1 ? "R4 last byte applied" : "R3 byte applied", chan_en, exp_en);
  endtask

  task automatic read_txn(input int nb);
    logic ack; logic [7:0] v;
    do_start();
    send_byte({dev_addr(strap), 1'b1}, 0, ack);
    chk("R1 read address ack", ack, 1);
    for (int k = 0; k < nb; k++) begin
      recv_byte(k != nb - 1, v);
      chk("R6 read value", v, exp_reg);
    end
    chk("R6 released after nack", sda_oe, 0);
    do_stop(); qb();
    chk("R5 read leaves enables", chan_en, exp_en);
  endtask

  initial begin
    logic ack; logic [7:0] v;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    chk("R7 reset enables", chan_en, 0);
    chk("R7 reset drive", sda_oe, 0);
    rst_n = 1'b1; qb();

    read_txn(1);                       // R6 read of reset value
    write_txn(1'b1, 1, 0);             // R3
    read_txn(3);                       // R6 repeated value

    // R3: all zeros is legal
    do_start(); send_byte({dev_addr(strap), 1'b0}, 0, ack);
    send_byte(8'h00, 0, ack); exp_reg = 8'h00;
    chk("R3 zero ack", ack, 1); do_stop(); qb(); exp_en = 8'h00;
    chk("R3 zero applied", chan_en, 8'h00);

    // R2: mismatch leaves SDA released
    mon = 1'b1; write_txn(1'b0, 2, 0); mon = 1'b0;
    chk("R2 no drive on mismatch", oe_seen, 0);

    // R8: spikes on SCL and SDA rejected
    write_txn(1'b1, 1, 1);
    write_txn(1'b1, 1, 2);

    // R9 and R5: write then repeated start into a read
    do_start(); send_byte({dev_addr(strap), 1'b0}, 0, ack);
    send_byte(8'hC3, 0, ack); exp_reg = 8'hC3;
    do_rstart(); send_byte({dev_addr(strap), 1'b1}, 0, ack);
    chk("R9 address after restart", ack, 1);
    recv_byte(1'b0, v);
    chk("R9 read after restart", v, 8'hC3);
    chk("R5 held across restart", chan_en, exp_en);
    do_stop(); qb(); exp_en = 8'hC3;
    chk("R5 applied on stop", chan_en, 8'hC3);

    // R1: other strap values
    for (int t = 0; t < 20; t++) begin
      strap = 3'($urandom);
      write_txn(($urandom % 8) != 0, 1 + ($urandom % 3), 0);
      if (($urandom % 4) == 0) read_txn(1 + ($urandom % 2));
    end

    // R7: reset mid transaction
    do_start(); send_byte({dev_addr(strap), 1'b0}, 0, ack);
    send_byte(8'hFF, 0, ack);
    rst_n = 1'b0; repeat (3) @(negedge clk);
    chk("R7 reset clears enables", chan_en, 0);
    rst_n = 1'b1; exp_reg = 8'h00; exp_en = 8'h00;
    do_stop(); qb();
    chk("R7 stays clear after stop", chan_en, 0);
    read_txn(1);

    chk("R10 drive stable while SCL high", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule